// File: doc/BRIEF.md
# Snooping MSI Cache Controller

This block is the per-processor controller of a small direct-mapped write-back cache. It keeps the cache coherent with peer caches on a shared broadcast bus. Coherence uses invalidation and three line states: Modified, Shared and Invalid. Each line holds one data word. The processor issues one read or write at a time. It holds the request until a one-cycle ready pulse, which carries the read data.

When a request cannot be served locally, the controller raises a bus request. It then checks the indexed line again in the cycle the grant arrives. From there it runs the whole transaction without releasing the bus:
- an optional write-back of a dirty victim;
- then a read miss, write miss or invalidate;
- then, for a miss, the wait for the fill.

A separate snoop port carries the transactions of the other caches. A snoop that hits a dirty line makes the controller supply the word and take over from memory. A snoop arriving while this controller holds the grant is its own traffic and is ignored.

Top module: `msi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, `req_ready_o`, `bus_req_o` and `snp_flush_o` are low, and the first access to any address goes to the bus.
- R2: A read whose tag matches a Shared or Modified line raises `req_ready_o` for exactly one cycle, in the cycle after the request is first seen. It returns the cached word and produces no bus command.
- R3: `bus_cmd_o` codes are 0 idle, 1 read miss, 2 write miss, 3 invalidate and 4 write-back. A read that finds the line Invalid, or Shared with another tag, issues code 1 with the request address. It waits for `bus_rsp_valid_i`, returns the response word and leaves the line Shared. The address is split as index = low 2 bits and tag = upper 6 bits.
- R4: A read or write that finds the indexed line Modified with another tag first issues code 4. That command carries the victim address and its data. The miss command follows in the very next cycle.
- R5: A write that hits a Shared line issues only code 3 with the request address. The next cycle is the ready pulse, and the line becomes Modified and holds the new word.
- R6: A write that hits a Modified line updates the word with no bus command and completes in one cycle.
- R7: A write that finds the line Invalid, or Shared with another tag, issues code 2. After the response it holds the written word in the Modified state.
- R8: A snooped read miss that hits a Modified line raises `snp_flush_o` in the next cycle with the line's word on `snp_data_o`, and leaves the line Shared. A hit on a Shared line raises no flush and keeps the line.
- R9: A snooped invalidate or write miss that hits a Shared line makes it Invalid.
- R10: A snooped write miss that hits a Modified line raises `snp_flush_o` in the next cycle with the line's word on `snp_data_o`, and makes the line Invalid.
- R11: Bus commands appear only while `bus_req_o` and `bus_gnt_i` are both high. `bus_req_o` stays high from the first command of a transaction until its response. A snoop presented while `bus_gnt_i` is high has no effect.
- R12: A snoop whose tag differs from the indexed line, or that hits an Invalid line, changes nothing and raises no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request, held until ready |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Write word |
| req_ready_o | output | 1 | One-cycle completion pulse |
| req_rdata_o | output | DATA_W | Read word, valid with ready |
| bus_req_o | output | 1 | Bus request, held for the whole transaction |
| bus_gnt_i | input | 1 | Bus grant |
| bus_cmd_o | output | 3 | Issued command (codes in R3) |
| bus_addr_o | output | ADDR_W | Command address |
| bus_data_o | output | DATA_W | Write-back word |
| bus_rsp_valid_i | input | 1 | Fill data valid |
| bus_rsp_data_i | input | DATA_W | Fill data |
| snp_valid_i | input | 1 | Snooped transaction valid |
| snp_cmd_i | input | 3 | Snooped command (codes in R3) |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_flush_o | output | 1 | Dirty line supplied, memory access aborted |
| snp_data_o | output | DATA_W | Supplied word |

## Verification
The hardest case to reach from the ports is a snoop that lands while this controller already holds the grant mid-transaction. The snoop must be ignored, even when it names a line that is dirty here. The bench forks a read miss on one index. A second thread waits until the grant is seen and then injects a write-miss snoop aimed at a Modified line on another index. It checks that no flush follows. A later snoop without the grant must still find the line dirty. Every index is also driven from each starting state through read and write, same-tag and different-tag requests. Each step is followed by matching and mismatching snoops, so that all processor-side and bus-side transitions are covered.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {LN_I = 2'd0, LN_S = 2'd1, LN_M = 2'd2} line_st_e;
  typedef enum logic [2:0] {
    BC_NONE = 3'd0, BC_RDMISS = 3'd1, BC_WRMISS = 3'd2, BC_INVAL = 3'd3, BC_WBACK = 3'd4
  } bus_cmd_e;
  typedef enum logic [2:0] {
    CS_IDLE, CS_ARB, CS_WBACK, CS_ISSUE, CS_FILL, CS_INVAL, CS_DONE
  } ctl_st_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  a_idx_i,
  output line_st_e          a_st_o,
  output logic [TAG_W-1:0]  a_tag_o,
  output logic [DATA_W-1:0] a_data_o,
  input  logic              a_we_i,
  input  line_st_e          a_st_i,
  input  logic [TAG_W-1:0]  a_tag_i,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic [IDX_W-1:0]  b_idx_i,
  output line_st_e          b_st_o,
  output logic [TAG_W-1:0]  b_tag_o,
  output logic [DATA_W-1:0] b_data_o,
  input  logic              b_we_i,
  input  line_st_e          b_st_i
);
  localparam int LINES = 1 << IDX_W;

  line_st_e          st_arr   [LINES];
  logic [TAG_W-1:0]  tag_arr  [LINES];
  logic [DATA_W-1:0] data_arr [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_e          st_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;
    logic              a_sel, b_sel;

    assign a_sel = a_we_i && (a_idx_i == IDX_W'(g));
    assign b_sel = b_we_i && (b_idx_i == IDX_W'(g));

    // processor-side write wins; the controller never issues both at once
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    st_q <= LN_I;
      else if (a_sel) st_q <= a_st_i;
      else if (b_sel) st_q <= b_st_i;
    end

    always_ff @(posedge clk_i) begin
      if (a_sel) begin
        tag_q  <= a_tag_i;
        data_q <= a_data_i;
      end
    end

    assign st_arr[g]   = st_q;
    assign tag_arr[g]  = tag_q;
    assign data_arr[g] = data_q;
  end

  assign a_st_o   = st_arr[a_idx_i];
  assign a_tag_o  = tag_arr[a_idx_i];
  assign a_data_o = data_arr[a_idx_i];
  assign b_st_o   = st_arr[b_idx_i];
  assign b_tag_o  = tag_arr[b_idx_i];
  assign b_data_o = data_arr[b_idx_i];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    snp_valid_i,
  input  logic [2:0]              snp_cmd_i,
  input  logic [ADDR_W-1:0]       snp_addr_i,
  input  logic                    own_bus_i,
  input  line_st_e                ln_st_i,
  input  logic [ADDR_W-IDX_W-1:0] ln_tag_i,
  input  logic [DATA_W-1:0]       ln_data_i,
  output logic [IDX_W-1:0]        ln_idx_o,
  output logic                    upd_en_o,
  output line_st_e                upd_st_o,
  output logic                    flush_o,
  output logic [DATA_W-1:0]       flush_data_o
);
  logic hit, flush_d;
  logic [DATA_W-1:0] flush_data_q;
  logic flush_q;

  assign ln_idx_o = snp_addr_i[IDX_W-1:0];
  assign hit = snp_valid_i && !own_bus_i && (ln_st_i != LN_I) &&
               (ln_tag_i == snp_addr_i[ADDR_W-1:IDX_W]);

  always_comb begin
    upd_en_o = 1'b0;
    upd_st_o = ln_st_i;
    flush_d  = 1'b0;
    if (hit) begin
      unique case (snp_cmd_i)
        BC_RDMISS: if (ln_st_i == LN_M) begin
          upd_en_o = 1'b1;
          upd_st_o = LN_S;
          flush_d  = 1'b1;
        end
        BC_WRMISS: begin
          upd_en_o = 1'b1;
          upd_st_o = LN_I;
          flush_d  = (ln_st_i == LN_M);
        end
        BC_INVAL: if (ln_st_i == LN_S) begin
          upd_en_o = 1'b1;
          upd_st_o = LN_I;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flush_q <= 1'b0;
    else         flush_q <= flush_d;
  end

  always_ff @(posedge clk_i) begin
    if (flush_d) flush_data_q <= ln_data_i;
  end

  assign flush_o      = flush_q;
  assign flush_data_o = flush_data_q;
endmodule

// File: rtl/msi_ctrl_fsm.sv
module msi_ctrl_fsm
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic                    req_we_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [DATA_W-1:0]       req_wdata_i,
  input  logic                    snp_busy_i,
  input  logic                    bus_gnt_i,
  input  logic                    bus_rsp_valid_i,
  input  logic [DATA_W-1:0]       bus_rsp_data_i,
  input  line_st_e                ln_st_i,
  input  logic [ADDR_W-IDX_W-1:0] ln_tag_i,
  input  logic [DATA_W-1:0]       ln_data_i,
  output logic [IDX_W-1:0]        ln_idx_o,
  output logic                    ln_we_o,
  output line_st_e                ln_st_o,
  output logic [ADDR_W-IDX_W-1:0] ln_tag_o,
  output logic [DATA_W-1:0]       ln_data_o,
  output logic                    req_ready_o,
  output logic [DATA_W-1:0]       req_rdata_o,
  output logic                    bus_req_o,
  output bus_cmd_e                bus_cmd_o,
  output logic [ADDR_W-1:0]       bus_addr_o,
  output logic [DATA_W-1:0]       bus_data_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  ctl_st_e state_q, state_d;
  logic              we_q, lat_en;
  logic [ADDR_W-1:0] addr_q, cur_addr;
  logic [DATA_W-1:0] wdata_q, rdata_q, rdata_d, cur_wdata;
  logic              cur_we, tag_eq;

  assign cur_addr  = (state_q == CS_IDLE) ? req_addr_i  : addr_q;
  assign cur_we    = (state_q == CS_IDLE) ? req_we_i    : we_q;
  assign cur_wdata = (state_q == CS_IDLE) ? req_wdata_i : wdata_q;
  assign ln_idx_o  = cur_addr[IDX_W-1:0];
  assign tag_eq    = (ln_st_i != LN_I) && (ln_tag_i == cur_addr[ADDR_W-1:IDX_W]);

  always_comb begin
    state_d     = state_q;
    lat_en      = 1'b0;
    ln_we_o     = 1'b0;
    ln_st_o     = LN_M;
    ln_tag_o    = cur_addr[ADDR_W-1:IDX_W];
    ln_data_o   = cur_wdata;
    rdata_d     = rdata_q;
    bus_req_o   = 1'b0;
    bus_cmd_o   = BC_NONE;
    bus_addr_o  = addr_q;
    bus_data_o  = ln_data_i;
    req_ready_o = 1'b0;
    unique case (state_q)
      CS_IDLE: if (req_valid_i && !snp_busy_i) begin
        lat_en = 1'b1;
        if (tag_eq && !cur_we) begin
          rdata_d = ln_data_i;
          state_d = CS_DONE;
        end else if (tag_eq && ln_st_i == LN_M) begin
          ln_we_o = 1'b1;
          rdata_d = cur_wdata;
          state_d = CS_DONE;
        end else begin
          state_d = CS_ARB;
        end
      end
      CS_ARB: begin
        bus_req_o = 1'b1;
        // re-examine the line: snoops may have changed it while waiting
        if (bus_gnt_i) begin
          if (tag_eq && !cur_we) begin
            rdata_d = ln_data_i;
            state_d = CS_DONE;
          end else if (tag_eq && ln_st_i == LN_M) begin
            ln_we_o = 1'b1;
            rdata_d = cur_wdata;
            state_d = CS_DONE;
          end else if (tag_eq) begin
            state_d = CS_INVAL;
          end else if (ln_st_i == LN_M) begin
            state_d = CS_WBACK;
          end else begin
            state_d = CS_ISSUE;
          end
        end
      end
      CS_WBACK: begin
        bus_req_o  = 1'b1;
        bus_cmd_o  = BC_WBACK;
        bus_addr_o = {ln_tag_i, addr_q[IDX_W-1:0]};
        state_d    = CS_ISSUE;
      end
      CS_ISSUE: begin
        bus_req_o = 1'b1;
        bus_cmd_o = we_q ? BC_WRMISS : BC_RDMISS;
        state_d   = CS_FILL;
      end
      CS_FILL: begin
        bus_req_o = 1'b1;
        if (bus_rsp_valid_i) begin
          ln_we_o   = 1'b1;
          ln_st_o   = we_q ? LN_M : LN_S;
          ln_data_o = we_q ? wdata_q : bus_rsp_data_i;
          rdata_d   = we_q ? wdata_q : bus_rsp_data_i;
          state_d   = CS_DONE;
        end
      end
      CS_INVAL: begin
        bus_req_o = 1'b1;
        bus_cmd_o = BC_INVAL;
        ln_we_o   = 1'b1;
        rdata_d   = wdata_q;
        state_d   = CS_DONE;
      end
      CS_DONE: begin
        req_ready_o = 1'b1;
        state_d     = CS_IDLE;
      end
      default: state_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= CS_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i) begin
    rdata_q <= rdata_d;
    if (lat_en) begin
      we_q    <= req_we_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  assign req_rdata_o = rdata_q;

  logic unused_tag;
  assign unused_tag = ^{TAG_W'(0)};
endmodule

// File: rtl/msi_cache_ctrl.sv
module msi_cache_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] req_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [2:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic              bus_rsp_valid_i,
  input  logic [DATA_W-1:0] bus_rsp_data_i,
  input  logic              snp_valid_i,
  input  logic [2:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_flush_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  a_idx, b_idx;
  line_st_e          a_st, b_st, a_wst, b_wst;
  logic [TAG_W-1:0]  a_tag, b_tag, a_wtag;
  logic [DATA_W-1:0] a_data, b_data, a_wdata;
  logic              a_we, b_we;
  bus_cmd_e          cmd;

  msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_store (
    .clk_i, .rst_ni,
    .a_idx_i(a_idx), .a_st_o(a_st), .a_tag_o(a_tag), .a_data_o(a_data),
    .a_we_i(a_we), .a_st_i(a_wst), .a_tag_i(a_wtag), .a_data_i(a_wdata),
    .b_idx_i(b_idx), .b_st_o(b_st), .b_tag_o(b_tag), .b_data_o(b_data),
    .b_we_i(b_we), .b_st_i(b_wst)
  );

  msi_snoop_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_snoop (
    .clk_i, .rst_ni,
    .snp_valid_i, .snp_cmd_i, .snp_addr_i,
    .own_bus_i(bus_gnt_i),
    .ln_st_i(b_st), .ln_tag_i(b_tag), .ln_data_i(b_data),
    .ln_idx_o(b_idx), .upd_en_o(b_we), .upd_st_o(b_wst),
    .flush_o(snp_flush_o), .flush_data_o(snp_data_o)
  );

  msi_ctrl_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_fsm (
    .clk_i, .rst_ni,
    .req_valid_i, .req_we_i, .req_addr_i, .req_wdata_i,
    .snp_busy_i(snp_valid_i),
    .bus_gnt_i, .bus_rsp_valid_i, .bus_rsp_data_i,
    .ln_st_i(a_st), .ln_tag_i(a_tag), .ln_data_i(a_data),
    .ln_idx_o(a_idx), .ln_we_o(a_we), .ln_st_o(a_wst), .ln_tag_o(a_wtag),
    .ln_data_o(a_wdata),
    .req_ready_o, .req_rdata_o,
    .bus_req_o, .bus_cmd_o(cmd), .bus_addr_o, .bus_data_o
  );

  assign bus_cmd_o = cmd;
endmodule

// File: rtl/msi_cache_ctrl_chk.sv
module msi_cache_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_req_o,
  input logic       bus_gnt_i,
  input logic [2:0] bus_cmd_o,
  input logic       req_ready_o,
  input logic       snp_valid_i,
  input logic       snp_flush_o
);
  AST_WBACK_THEN_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o == 3'd4) |=> (bus_cmd_o == 3'd1 || bus_cmd_o == 3'd2)); // R4
  AST_INVAL_THEN_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o == 3'd3) |=> req_ready_o); // R5
  AST_READY_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> !req_ready_o); // R2
  AST_CMD_WHEN_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o != 3'd0) |-> (bus_req_o && bus_gnt_i)); // R11
  AST_MISS_KEEPS_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o == 3'd1 || bus_cmd_o == 3'd2) |=> bus_req_o); // R11
  AST_NO_SELF_SNOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && bus_gnt_i) |=> !snp_flush_o); // R11
  AST_FLUSH_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_flush_o |-> $past(snp_valid_i && !bus_gnt_i)); // R8
endmodule

bind msi_cache_ctrl msi_cache_ctrl_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i),
  .bus_cmd_o(bus_cmd_o), .req_ready_o(req_ready_o), .snp_valid_i(snp_valid_i),
  .snp_flush_o(snp_flush_o)
);

// File: tb/test_msi_cache_ctrl.sv
module test_msi_cache_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_we = 0;
  logic [7:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic req_ready;
  logic [15:0] req_rdata;
  logic bus_req, bus_gnt = 0;
  logic [2:0] bus_cmd;
  logic [7:0] bus_addr;
  logic [15:0] bus_data;
  logic rsp_valid = 0;
  logic [15:0] rsp_data = 0;
  logic snp_valid = 0;
  logic [2:0] snp_cmd = 0;
  logic [7:0] snp_addr = 0;
  logic snp_flush;
  logic [15:0] snp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_cache_ctrl i_msi_cache_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_ready_o(req_ready), .req_rdata_o(req_rdata),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd),
    .bus_addr_o(bus_addr), .bus_data_o(bus_data),
    .bus_rsp_valid_i(rsp_valid), .bus_rsp_data_i(rsp_data),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .snp_flush_o(snp_flush), .snp_data_o(snp_data)
  );

  int n_cmp = 0, n_bad = 0;
  logic [15:0] mem [256];
  int m_st [4];            // 0 I, 1 S, 2 M
  logic [5:0] m_tag [4];
  logic [15:0] m_dat [4];

  int n_log = 0;
  logic [2:0] log_cmd [8];
  logic [7:0] log_addr [8];
  logic [15:0] log_data [8];

  // arbiter and memory on the bus side
  int rcnt = 0;
  logic [7:0] raddr = 0;
  always @(posedge clk) begin
    bus_gnt <= rst_n ? bus_req : 1'b0;
    if (bus_cmd == 3'd4) mem[bus_addr] = bus_data;
    if (bus_cmd == 3'd1 || bus_cmd == 3'd2) begin
      rcnt <= 2; raddr <= bus_addr; rsp_valid <= 1'b0;
    end else if (rcnt != 0) begin
      rcnt <= rcnt - 1; rsp_valid <= (rcnt == 1); rsp_data <= mem[raddr];
    end else rsp_valid <= 1'b0;
  end

  always @(negedge clk) begin
    if (bus_cmd != 3'd0 && n_log < 8) begin
      log_cmd[n_log] = bus_cmd; log_addr[n_log] = bus_addr; log_data[n_log] = bus_data;
      n_log = n_log + 1;
    end
  end

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic do_op(input logic we, input logic [7:0] a, input logic [15:0] wd);
    int idx = int'(a[1:0]);
    logic [5:0] tg = a[7:2];
    bit hit = (m_st[idx] != 0) && (m_tag[idx] == tg);
    int en = 0, lat = 0;
    logic [2:0] ec [2];
    logic [7:0] ea [2];
    logic [15:0] ed, erd;
    string r;
    if (!we && hit) begin r = "R2"; erd = m_dat[idx]; end
    else if (we && hit && m_st[idx] == 2) begin r = "R6"; erd = wd; m_dat[idx] = wd; end
    else if (we && hit) begin
      r = "R5"; en = 1; ec[0] = 3'd3; ea[0] = a; erd = wd; m_st[idx] = 2; m_dat[idx] = wd;
    end else begin
      r = we ? "R7" : "R3";
      if (m_st[idx] == 2) begin
        r = "R4"; ec[0] = 3'd4; ea[0] = {m_tag[idx], a[1:0]}; ed = m_dat[idx]; en = 1;
      end
      ec[en] = we ? 3'd2 : 3'd1; ea[en] = a; en++;
      erd = we ? wd : mem[a];
      m_st[idx] = we ? 2 : 1; m_tag[idx] = tg; m_dat[idx] = erd;
    end
    @(negedge clk);
    n_log = 0;
    req_valid = 1; req_we = we; req_addr = a; req_wdata = wd;
    do begin @(negedge clk); lat++; end while (!req_ready);
    req_valid = 0;
    chk(req_rdata == erd, r, req_rdata, erd);
    chk(n_log == en, r, n_log, en);
    if (en == 0) chk(lat == 1, r, lat, 1);
    for (int k = 0; k < en && k < n_log; k++) begin
      chk(log_cmd[k] == ec[k], r, log_cmd[k], ec[k]);
      chk(log_addr[k] == ea[k], r, log_addr[k], ea[k]);
      if (ec[k] == 3'd4) chk(log_data[k] == ed, r, log_data[k], ed);
    end
  endtask

  task automatic snoop(input logic [2:0] c, input logic [7:0] a);
    int idx = int'(a[1:0]);
    bit hit = (m_st[idx] != 0) && (m_tag[idx] == a[7:2]);
    bit efl = 0;
    logic [15:0] ed = m_dat[idx];
    string r = "R12";
    if (hit) begin
      if (c == 3'd1 && m_st[idx] == 2) begin efl = 1; m_st[idx] = 1; r = "R8"; end
      else if (c == 3'd1) r = "R8";
      else if (c == 3'd2 && m_st[idx] == 2) begin efl = 1; m_st[idx] = 0; r = "R10"; end
      else if (m_st[idx] == 1 && (c == 3'd2 || c == 3'd3)) begin m_st[idx] = 0; r = "R9"; end
    end
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    @(negedge clk);
    snp_valid = 0;
    chk(snp_flush == efl, r, snp_flush, efl);
    if (efl) begin
      chk(snp_data == ed, r, snp_data, ed);
      mem[a] = snp_data;
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R11 watchdog actual=0 expected=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 7 + 3);
    for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_tag[i] = 0; m_dat[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 0, "R1", req_ready, 0);
    chk(bus_req == 0, "R1", bus_req, 0);
    chk(snp_flush == 0, "R1", snp_flush, 0);
    for (int i = 0; i < 4; i++) do_op(0, 8'(8'h40 + i), 16'h0); // R1: every line starts Invalid

    for (int idx = 0; idx < 4; idx++)
      for (int s0 = 0; s0 < 3; s0++)
        for (int op = 0; op < 4; op++) begin
          logic [5:0] ta = 6'(idx * 9 + s0 * 3 + op + 1);
          logic [7:0] a = {ta, 2'(idx)};
          logic [7:0] b = {ta ^ 6'h15, 2'(idx)};
          logic [7:0] t = (op[0]) ? b : a;
          logic [15:0] pat = 16'(16'h1000 + idx * 256 + s0 * 16 + op);
          do_op(1, a, pat);
          if (s0 == 0) snoop(3'd2, a);
          if (s0 == 1) snoop(3'd1, a);
          do_op(op[1], t, pat ^ 16'h5a5a);
          snoop(3'd2, t ^ 8'h80);          // mismatching tag
          do_op(0, t, 16'h0);
          snoop(3'd1, t);
          snoop(3'd1, t);
          snoop(3'd3, t);
          do_op(0, t, 16'h0);
          do_op(1, t, pat + 16'h0101);
          snoop(3'd2, t);
        end

    // snoop while this controller holds the grant
    do_op(1, 8'h25, 16'hbeef);             // index 1 Modified
    fork
      do_op(0, 8'h32, 16'h0);              // read miss on index 2
      begin
        do @(negedge clk); while (!bus_gnt);
        snp_valid = 1; snp_cmd = 3'd2; snp_addr = 8'h25;
        @(negedge clk);
        snp_valid = 0;
        chk(snp_flush == 0, "R11", snp_flush, 0);
      end
    join
    snoop(3'd2, 8'h25);                     // still dirty: flush expected

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule